// File: doc/BRIEF.md
# UART Transmitter with Parity

This block turns a parallel byte into one asynchronous serial frame on a single output line. A frame is a low start bit, the eight data bits least significant first, one parity bit and a high stop bit. Between frames the line rests high, so every frame opens with a falling edge. Each bit lasts a fixed number of periods of a clock enable that runs at sixteen times the baud rate. The baud divider that makes this enable is outside the block.

The host places a byte on the data input and pulls the active-low write strobe for one clock. The byte goes into a holding register. On the next clock, if the shifter is idle, the byte moves into the shift register and transmission starts. While a frame is shifting, the host may load the next byte into the holding register. That byte follows the current stop bit with no idle gap. Two flags report the state: one is high while the shifter is idle, the other is high while the holding register is free. A write that arrives while the holding register is occupied is dropped.

Top module: `uart_tx_parity`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and right after it, `txd` is 1, `shift_idle` is 1 and `buf_empty` is 1.
- R2: A frame on `txd` is one 0 start bit, then data bits 0 through 7 in that order (LSB first), then the parity bit, then one 1 stop bit. The line is 1 when idle.
- R3: Every data bit stays on `txd` for exactly OVERSAMPLE (default 16) asserted cycles of `tick`.
- R4: With PARITY_ODD = 0 (default), the parity bit makes the count of ones over data and parity even. With PARITY_ODD = 1, the count is odd.
- R5: While `wr_n` is 1, `din` is not captured: `buf_empty` stays 1 and `txd` stays idle.
- R6: `shift_idle` falls on the clock that moves a byte into the shifter, and `txd` shows the start bit from that same clock. It stays 0 until the stop bit completes, then returns to 1.
- R7: An accepted write (`wr_n` = 0 while `buf_empty` = 1) clears `buf_empty` on that clock edge. `buf_empty` returns to 1 on the clock that moves the byte into the shifter. When the shifter is idle, that is the next clock.
- R8: A write while `buf_empty` is 0 is ignored. The byte in the holding register is the one that is sent, and no extra frame appears.
- R9: A byte held while a frame is shifting starts its start bit on the same clock the previous stop bit ends. `shift_idle` stays 0 across the boundary.
- R10: Asserting reset in the middle of a frame immediately returns `txd` high and both flags to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable at OVERSAMPLE times the baud rate |
| wr_n | input | 1 | Write strobe, active low |
| din | input | DATA_W | Byte to send |
| txd | output | 1 | Serial line, idle high |
| shift_idle | output | 1 | 1 when no frame is being shifted |
| buf_empty | output | 1 | 1 when the holding register can take a byte |

## Verification
The bench builds two instances side by side from the same stimulus. One uses the defaults (OVERSAMPLE = 16, even parity). The other sets PARITY_ODD = 1. Their lines must agree on every bit except parity, where they must differ, so both parity senses are covered by every vector. The clock enable runs at one clock in three, not every clock. This makes bit length a count of enables rather than of clocks. It also lets the first bit after a load start out of phase with the enable, so the mid-bit sampling window is exercised under realistic alignment.

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic              txd,
  output logic              shift_idle,
  output logic              buf_empty
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int SUB_W   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic [DATA_W-1:0]  hold_q;
  logic               empty_q;
  logic               busy_q;
  logic [FRAME_W-1:0] frame_q;
  logic [SUB_W-1:0]   sub_q;
  logic [BIT_W-1:0]   bit_q;

  logic accept, bit_end, last_bit, load, par;

  assign accept   = !wr_n && empty_q;
  assign bit_end  = busy_q && tick && (sub_q == SUB_LAST);
  assign last_bit = bit_end && (bit_q == BIT_LAST);
  assign load     = !empty_q && (!busy_q || last_bit);
  assign par      = (^hold_q) ^ PARITY_ODD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else if (accept) begin
      hold_q  <= din;
      empty_q <= 1'b0;
    end else if (load) begin
      empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      busy_q  <= 1'b0;
      sub_q   <= '0;
      bit_q   <= '0;
    end else if (load) begin
      frame_q <= {1'b1, par, hold_q, 1'b0};
      busy_q  <= 1'b1;
      sub_q   <= '0;
      bit_q   <= '0;
    end else if (bit_end) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      sub_q   <= '0;
      bit_q   <= bit_q + 1'b1;
      if (last_bit) busy_q <= 1'b0;
    end else if (busy_q && tick) begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign txd        = frame_q[0];
  assign shift_idle = !busy_q;
  assign buf_empty  = empty_q;
endmodule

// File: rtl/uart_tx_parity_chk.sv
module uart_tx_parity_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic wr_n,
  input logic txd,
  input logic shift_idle,
  input logic buf_empty
);
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_idle |-> txd);

  assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_idle) |-> !txd);

  assert_empty_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> !shift_idle);

  assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> $past(!wr_n));

  assert_bit_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> ($past(tick) || $fell(shift_idle)));
endmodule

bind uart_tx_parity uart_tx_parity_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_n(wr_n),
  .txd(txd), .shift_idle(shift_idle), .buf_empty(buf_empty)
);

// File: tb/sim_uart_tx_parity.sv
module sim_uart_tx_parity;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic txd, shift_idle, buf_empty;
  logic txd1, shift_idle1, buf_empty1;
  logic [1:0] tdiv = 2'd0;
  int checks = 0;
  int errors = 0;

  localparam logic [8:0] VEC [8] = '{
    {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h01}, {1'b0, 8'hA5},
    {1'b1, 8'h80}, {1'b0, 8'h7E}, {1'b1, 8'h37}, {1'b0, 8'h5A}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
    tick <= (tdiv == 2'd2);
  end

  uart_tx_parity u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_n(wr_n), .din(din),
    .txd(txd), .shift_idle(shift_idle), .buf_empty(buf_empty)
  );

  uart_tx_parity #(.PARITY_ODD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_n(wr_n), .din(din),
    .txd(txd1), .shift_idle(shift_idle1), .buf_empty(buf_empty1)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    din  = d;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic send_check(input logic [7:0] d, input logic pe);
    write_byte(d);
    chk(buf_empty == 1'b0, "R7 empty falls on write", buf_empty, 0);
    chk(shift_idle == 1'b1, "R7 shifter idle before move", shift_idle, 1);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R7 empty rises on move", buf_empty, 1);
    chk(shift_idle == 1'b0, "R6 idle falls on start", shift_idle, 0);
    chk(txd == 1'b0, "R6 start shown at once", txd, 0);
    repeat (24) @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    chk(txd1 == 1'b0, "R2 start bit odd inst", txd1, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      chk(txd == d[i], "R2 data bit", txd, d[i]);
      chk(txd1 == d[i], "R2 data bit odd inst", txd1, d[i]);
    end
    repeat (BITC) @(negedge clk);
    chk(txd == pe, "R4 even parity", txd, pe);
    chk(txd1 == !pe, "R4 odd parity", txd1, !pe);
    repeat (BITC) @(negedge clk);
    chk(txd == 1'b1, "R2 stop bit", txd, 1);
    chk(shift_idle == 1'b0, "R6 busy through stop", shift_idle, 0);
    repeat (40) @(negedge clk);
    chk(shift_idle == 1'b1, "R6 idle after frame", shift_idle, 1);
    chk(txd == 1'b1, "R2 line idle high", txd, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] fa, fb;
    int n;
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd in reset", txd, 1);
    chk(shift_idle == 1'b1, "R1 idle in reset", shift_idle, 1);
    chk(buf_empty == 1'b1, "R1 empty in reset", buf_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && shift_idle && buf_empty, "R1 state after reset", {txd, shift_idle, buf_empty}, 7);

    for (int v = 0; v < 8; v++) send_check(VEC[v][7:0], VEC[v][8]);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      din = 8'(i * 37 + 5);
      chk(buf_empty == 1'b1 && txd == 1'b1, "R5 no capture while wr_n high",
          {buf_empty, txd}, 3);
    end

    write_byte(8'h01);
    @(negedge clk);
    while (!txd) @(negedge clk);
    n = 0;
    while (txd) begin n++; @(negedge clk); end
    chk(n == BITC, "R3 bit length", n, BITC);
    repeat (600) @(negedge clk);

    fa = {1'b1, ^8'h3C, 8'h3C, 1'b0};
    fb = {1'b1, ^8'hC3, 8'hC3, 1'b0};
    write_byte(8'h3C);
    @(negedge clk);
    write_byte(8'hC3);
    chk(buf_empty == 1'b0 && shift_idle == 1'b0, "R9 second byte held while shifting",
        {buf_empty, shift_idle}, 0);
    write_byte(8'hFF);
    chk(buf_empty == 1'b0, "R8 write while full", buf_empty, 0);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 22; k++) begin
      if (k > 0) repeat (BITC) @(negedge clk);
      if (k < 11) chk(txd == fa[k], "R8 first frame bit", txd, fa[k]);
      else chk(txd == fb[k-11], "R9 second frame bit", txd, fb[k-11]);
      chk(shift_idle == 1'b0, "R9 no gap between frames", shift_idle, 0);
    end
    repeat (40) @(negedge clk);
    chk(shift_idle && buf_empty && txd, "R8 dropped byte never sent",
        {shift_idle, buf_empty, txd}, 7);
    repeat (600) @(negedge clk);
    chk(shift_idle && txd, "R8 no extra frame", {shift_idle, txd}, 3);

    write_byte(8'h00);
    repeat (100) @(negedge clk);
    chk(txd == 1'b0, "R10 mid-frame line low", txd, 0);
    rst_n = 1'b0;
    #1;
    chk(txd && shift_idle && buf_empty, "R10 async reset mid-frame",
        {txd, shift_idle, buf_empty}, 7);
    @(negedge clk);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule